// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block turns a 32-bit virtual address into a physical address and a fault code. It serves an instruction fetch, a data read or a data write. Each request carries its access kind, its address, and three mode flags:

- the privilege level of the core;
- whether translation is enabled;
- whether single-virtual mode is selected.

**Fixed areas.** The upper address areas are decoded first and are never translated.

**Table lookup.** All other addresses are looked up in a small, fully associative table of page entries. Each entry has these fields:

- virtual page number;
- address-space identifier;
- valid and shared flags;
- a page-size code;
- physical page number;
- two protection bits;
- a dirty bit.

**Faults.** The block checks for a miss, a multiple hit, a protection violation and a first write to a clean page. A fault produces a fixed exception code. The block then latches the faulting address. Except on a multiple hit, it also replaces the page-number part of its page-table-entry-high register with the faulting address bits. The identifier held in the low bits of that register is kept.

**Loading and timing.** Software loads entries through a one-entry-per-cycle write port and writes the page-table-entry-high register directly. A request is registered on the first edge. The lookup is combinational from that registered request. The result is registered on the next edge.

Top module: `vat_checker`

## Requirements
- R1: After reset `rsp_valid` is 0, `fault_addr` is 0 and `pteh_q` is 0.
- R2: A request accepted with `req_valid` high gives exactly one `rsp_valid` pulse, two clock edges later. No pulse appears without a request.
- R3: In privileged mode (`req_user`=0), addresses 0x80000000–0xBFFFFFFF map to the address with bits 31:29 cleared. Addresses 0xE0000000 and above pass through unchanged. Neither case faults.
- R4: In user mode, an access to 0x80000000–0xBFFFFFFF or to 0xE0000000 and above faults with code 0x0E0 for a read or fetch and 0x100 for a write. The exception is 0xE0000000–0xE3FFFFFF, which passes through unchanged.
- R5: With `req_xlat_en`=0, any other address maps to the address with bits 31:29 cleared and does not fault.
- R6: An entry with valid=0 never matches. The entry identifier is compared with `pteh_q[7:0]` only when `req_single_virt`=0 or `req_user`=1. The comparison is skipped for entries with shared=1.
- R7: Size code 0/1/2/3 selects 1 KB/4 KB/64 KB/1 MB pages. The page number is compared only above the page size. The physical address is `{ppn,10'b0}` above the page size joined with the address bits below it.
- R8: More than one matching entry gives code 0x140. No matching entry gives 0x040 for a read or fetch and 0x060 for a write.
- R9: In user mode, a hit on an entry whose protection bit 1 is 0 gives 0x0A0 for a read or fetch and 0x0C0 for a write.
- R10: Otherwise, a write hitting an entry with protection bit 0 clear gives 0x0C0. A write hitting an entry with dirty=0 gives 0x080. Both checks are skipped for reads and fetches.
- R11: On any fault `fault_addr` takes the request address. Except on 0x140, `pteh_q[31:10]` takes address bits 31:10 and `pteh_q[9:0]` is kept. A result without a fault changes neither register.
- R12: `pteh_wr` loads `pteh_wdata` into `pteh_q` on the next edge.
- R13: `ent_we` writes all fields of entry `ent_idx` on the next edge. The new entry governs requests whose lookup comes after that edge.

Access kind encoding: `req_kind` 0 = read, 1 = write, 2 = fetch, 3 = read. Fault code 0 with `rsp_fault`=0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_addr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_xlat_en | input | 1 | Translation enable |
| req_single_virt | input | 1 | Single-virtual mode (skips the identifier check in privileged mode) |
| pteh_wr | input | 1 | Write strobe for the page-table-entry-high register |
| pteh_wdata | input | 32 | Value written to that register |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Entry index to write |
| ent_vpn | input | 22 | Virtual page number (address bits 31:10) |
| ent_asid | input | ASID_W | Address-space identifier |
| ent_valid | input | 1 | Valid flag |
| ent_shared | input | 1 | Shared flag |
| ent_size | input | 2 | Page size code |
| ent_ppn | input | 19 | Physical page number (address bits 28:10) |
| ent_prot | input | 2 | Protection: bit 1 user access, bit 0 writable |
| ent_dirty | input | 1 | Dirty flag |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Exception code, 0 on success |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| fault_addr | output | 32 | Last faulting virtual address |
| pteh_q | output | 32 | Page-table-entry-high register |

## Verification
Addresses in each fixed area are sent in both privileges. This separates the P1/P2 masking, the upper-area pass-through and the user-mode exception window from the translated path. Translation-off requests use addresses in the translatable range, so masking is seen apart from the table. Table requests cover four page sizes and offsets just inside and just outside a page. They also vary the identifier, shared and valid flags, and the single-virtual flag in both privileges. Overlapping entries and entries with each protection and dirty combination separate the multiple-hit, miss, violation and initial-write codes. The tests also check which of these faults leave `pteh_q` untouched.

// File: rtl/vat_checker.sv
module vat_checker #(
  parameter int ENTRIES = 4,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [31:0]       req_addr,
  input  logic              req_user,
  input  logic              req_xlat_en,
  input  logic              req_single_virt,
  input  logic              pteh_wr,
  input  logic [31:0]       pteh_wdata,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [21:0]       ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_valid,
  input  logic              ent_shared,
  input  logic [1:0]        ent_size,
  input  logic [18:0]       ent_ppn,
  input  logic [1:0]        ent_prot,
  input  logic              ent_dirty,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [11:0]       rsp_code,
  output logic [31:0]       rsp_paddr,
  output logic [31:0]       fault_addr,
  output logic [31:0]       pteh_q
);
  localparam logic [11:0] C_OK       = 12'h000;
  localparam logic [11:0] C_MISS_RD  = 12'h040;
  localparam logic [11:0] C_MISS_WR  = 12'h060;
  localparam logic [11:0] C_INIT_WR  = 12'h080;
  localparam logic [11:0] C_PROT_RD  = 12'h0A0;
  localparam logic [11:0] C_PROT_WR  = 12'h0C0;
  localparam logic [11:0] C_AERR_RD  = 12'h0E0;
  localparam logic [11:0] C_AERR_WR  = 12'h100;
  localparam logic [11:0] C_MULTI    = 12'h140;

  function automatic logic [31:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = 32'h0000_03FF;
      2'd1:    page_mask = 32'h0000_0FFF;
      2'd2:    page_mask = 32'h0000_FFFF;
      default: page_mask = 32'h000F_FFFF;
    endcase
  endfunction

  logic [21:0]       e_vpn   [ENTRIES];
  logic [ASID_W-1:0] e_asid  [ENTRIES];
  logic [18:0]       e_ppn   [ENTRIES];
  logic [1:0]        e_size  [ENTRIES];
  logic [1:0]        e_prot  [ENTRIES];
  logic [ENTRIES-1:0] e_v, e_sh, e_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= '0; e_sh <= '0; e_d <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0; e_asid[i] <= '0; e_ppn[i] <= '0;
        e_size[i] <= '0; e_prot[i] <= '0;
      end
    end else if (ent_we) begin
      e_vpn[ent_idx]  <= ent_vpn;
      e_asid[ent_idx] <= ent_asid;
      e_ppn[ent_idx]  <= ent_ppn;
      e_size[ent_idx] <= ent_size;
      e_prot[ent_idx] <= ent_prot;
      e_v[ent_idx]    <= ent_valid;
      e_sh[ent_idx]   <= ent_shared;
      e_d[ent_idx]    <= ent_dirty;
    end
  end

  logic        q_v, q_user, q_xlat, q_sv;
  logic [1:0]  q_kind;
  logic [31:0] q_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v <= 1'b0; q_user <= 1'b0; q_xlat <= 1'b0; q_sv <= 1'b0;
      q_kind <= '0; q_addr <= '0;
    end else begin
      q_v <= req_valid;
      if (req_valid) begin
        q_user <= req_user; q_xlat <= req_xlat_en; q_sv <= req_single_virt;
        q_kind <= req_kind; q_addr <= req_addr;
      end
    end
  end

  wire is_wr    = (q_kind == 2'd1);
  wire use_asid = !q_sv || q_user;
  wire in_p12   = (q_addr[31:30] == 2'b10);
  wire in_p4    = (q_addr[31:29] == 3'b111);
  wire in_sq    = (q_addr[31:26] == 6'b111000);

  logic [ENTRIES-1:0] hit;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    wire [31:0] base    = {e_vpn[g], 10'b0};
    wire [31:0] off_m   = page_mask(e_size[g]);
    wire        asid_ok = e_sh[g] || !use_asid || (e_asid[g] == pteh_q[ASID_W-1:0]);
    assign hit[g] = e_v[g] && asid_ok && (((q_addr ^ base) & ~off_m) == 32'h0);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) sel = IDX_W'(i);
  end

  wire        any_hit = |hit;
  wire        multi   = ($countones(hit) > 1);
  wire [31:0] sel_m   = page_mask(e_size[sel]);
  wire [1:0]  sel_pr  = e_prot[sel];

  logic [11:0] code;
  logic [31:0] paddr;
  always_comb begin
    code  = C_OK;
    paddr = 32'h0;
    if (in_p12 || in_p4) begin
      if (q_user && !in_sq) code = is_wr ? C_AERR_WR : C_AERR_RD;
      else paddr = in_p12 ? {3'b000, q_addr[28:0]} : q_addr;
    end else if (!q_xlat) begin
      paddr = {3'b000, q_addr[28:0]};
    end else if (multi) begin
      code = C_MULTI;
    end else if (!any_hit) begin
      code = is_wr ? C_MISS_WR : C_MISS_RD;
    end else if (q_user && !sel_pr[1]) begin
      code = is_wr ? C_PROT_WR : C_PROT_RD;
    end else if (is_wr && !sel_pr[0]) begin
      code = C_PROT_WR;
    end else if (is_wr && !e_d[sel]) begin
      code = C_INIT_WR;
    end else begin
      paddr = ({3'b000, e_ppn[sel], 10'b0} & ~sel_m) | (q_addr & sel_m);
    end
  end

  wire fault_now = q_v && (code != C_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_fault <= 1'b0; rsp_code <= '0; rsp_paddr <= '0;
      fault_addr <= '0; pteh_q <= '0;
    end else begin
      rsp_valid <= q_v;
      if (q_v) begin
        rsp_fault <= (code != C_OK);
        rsp_code  <= code;
        rsp_paddr <= paddr;
      end
      if (fault_now) fault_addr <= q_addr;
      if (fault_now && code != C_MULTI) pteh_q <= {q_addr[31:10], pteh_q[9:0]};
      else if (pteh_wr) pteh_q <= pteh_wdata;
    end
  end

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    q_v |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !q_v |=> !rsp_valid);
  a_r11_tea_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    q_v |=> (!rsp_fault || fault_addr == $past(q_addr)));
  a_r11_ok_keeps_tea: assert property (@(posedge clk) disable iff (!rst_n)
    (q_v && code == C_OK) |=> $stable(fault_addr));
  a_r11_asid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_now && !pteh_wr) |=> pteh_q[9:0] == $past(pteh_q[9:0]));
  a_r4_user_window: assert property (@(posedge clk) disable iff (!rst_n)
    (q_v && q_user && code == C_OK) |=>
      (rsp_paddr[31:29] == 3'b000 || rsp_paddr[31:26] == 6'b111000));
  a_r8_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_code != 12'h000)));
endmodule

// File: tb/vat_checker_tb.sv
module vat_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_user = 0, req_xlat_en = 0, req_single_virt = 0;
  logic [1:0] req_kind = 0;
  logic [31:0] req_addr = 0;
  logic pteh_wr = 0;
  logic [31:0] pteh_wdata = 0;
  logic ent_we = 0, ent_valid = 0, ent_shared = 0, ent_dirty = 0;
  logic [IW-1:0] ent_idx = 0;
  logic [21:0] ent_vpn = 0;
  logic [7:0] ent_asid = 0;
  logic [1:0] ent_size = 0, ent_prot = 0;
  logic [18:0] ent_ppn = 0;
  logic rsp_valid, rsp_fault;
  logic [11:0] rsp_code;
  logic [31:0] rsp_paddr, fault_addr, pteh_q;

  int checks = 0, failures = 0;
  bit done = 0;

  vat_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_user(req_user), .req_xlat_en(req_xlat_en),
    .req_single_virt(req_single_virt), .pteh_wr(pteh_wr), .pteh_wdata(pteh_wdata),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .ent_valid(ent_valid), .ent_shared(ent_shared), .ent_size(ent_size),
    .ent_ppn(ent_ppn), .ent_prot(ent_prot), .ent_dirty(ent_dirty),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .fault_addr(fault_addr), .pteh_q(pteh_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic load_entry(int idx, logic [21:0] vpn, logic [7:0] asid, logic v,
                            logic sh, logic [1:0] sz, logic [18:0] ppn,
                            logic [1:0] pr, logic d);
    @(negedge clk);
    ent_we = 1; ent_idx = IW'(idx); ent_vpn = vpn; ent_asid = asid; ent_valid = v;
    ent_shared = sh; ent_size = sz; ent_ppn = ppn; ent_prot = pr; ent_dirty = d;
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic access(string tag, logic [1:0] kind, logic [31:0] addr, logic user,
                        logic xlat, logic sv, logic [11:0] exp_code, logic [31:0] exp_pa);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = addr; req_user = user;
    req_xlat_en = xlat; req_single_virt = sv;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R2 no early rsp"}, 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk({tag, " R2 rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " code"}, 32'(rsp_code), 32'(exp_code));
    chk({tag, " fault flag"}, 32'(rsp_fault), 32'(exp_code != 12'h000));
    if (exp_code == 12'h000) chk({tag, " paddr"}, rsp_paddr, exp_pa);
    @(negedge clk);
    chk({tag, " R2 single pulse"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 fault_addr", fault_addr, 0);
    chk("R1 pteh", pteh_q, 0);
  endtask

  task automatic t_areas();
    access("R3 P1 priv read", 2'd0, 32'h9234_5678, 0, 1, 0, 12'h000, 32'h1234_5678);
    access("R3 P2 priv fetch", 2'd2, 32'hA000_0010, 0, 1, 0, 12'h000, 32'h0000_0010);
    access("R3 P4 priv write", 2'd1, 32'hF000_0010, 0, 1, 0, 12'h000, 32'hF000_0010);
    access("R4 user read P1", 2'd0, 32'h8000_0000, 1, 1, 0, 12'h0E0, 0);
    chk("R11 tea after R4", fault_addr, 32'h8000_0000);
    access("R4 user write P2", 2'd1, 32'hA000_0000, 1, 1, 0, 12'h100, 0);
    access("R4 user fetch P4", 2'd2, 32'hF000_0000, 1, 1, 0, 12'h0E0, 0);
    access("R4 user window end", 2'd0, 32'hE3FF_FFFC, 1, 1, 0, 12'h000, 32'hE3FF_FFFC);
    access("R4 user past window", 2'd0, 32'hE400_0000, 1, 1, 0, 12'h0E0, 0);
  endtask

  task automatic t_xlat_off();
    access("R5 off user read", 2'd0, 32'h4567_89AB, 1, 0, 0, 12'h000, 32'h0567_89AB);
    access("R5 off write", 2'd1, 32'hC123_4567, 0, 0, 0, 12'h000, 32'h0123_4567);
  endtask

  task automatic t_pteh_write();
    @(negedge clk); pteh_wr = 1; pteh_wdata = 32'h0000_0005;
    @(negedge clk); pteh_wr = 0;
    chk("R12 pteh load", pteh_q, 32'h0000_0005);
  endtask

  task automatic t_basic_hit();
    load_entry(0, 22'h1000, 8'h05, 1, 0, 2'd1, 19'h0C000, 2'b11, 1);
    access("R13 R7 4K hit", 2'd0, 32'h0040_0ABC, 1, 1, 0, 12'h000, 32'h0300_0ABC);
    access("R7 4K write hit", 2'd1, 32'h0040_0FFF, 1, 1, 0, 12'h000, 32'h0300_0FFF);
  endtask

  task automatic t_asid();
    load_entry(1, 22'h2000, 8'h09, 1, 0, 2'd2, 19'h14000, 2'b11, 1);
    access("R6 R8 asid mismatch user miss", 2'd0, 32'h0080_1234, 1, 1, 0, 12'h040, 0);
    access("R8 write miss", 2'd1, 32'h0080_1234, 1, 1, 0, 12'h060, 0);
    access("R6 priv sv=0 miss", 2'd2, 32'h0080_1234, 0, 1, 0, 12'h040, 0);
    access("R6 priv sv=1 hit", 2'd0, 32'h0080_1234, 0, 1, 1, 12'h000, 32'h0500_1234);
    access("R6 user sv=1 still miss", 2'd0, 32'h0080_1234, 1, 1, 1, 12'h040, 0);
    load_entry(1, 22'h2000, 8'h09, 1, 1, 2'd2, 19'h14000, 2'b11, 1);
    access("R6 shared user hit 64K", 2'd0, 32'h0080_FFF0, 1, 1, 0, 12'h000, 32'h0500_FFF0);
  endtask

  task automatic t_big_page();
    load_entry(2, 22'h48CFF, 8'h05, 1, 0, 2'd3, 19'h2ACFF, 2'b10, 0);
    access("R7 1M hit", 2'd0, 32'h123F_EDCB, 1, 1, 0, 12'h000, 32'h0ABF_EDCB);
    access("R10 write not writable", 2'd1, 32'h1230_0000, 0, 1, 0, 12'h0C0, 0);
  endtask

  task automatic t_protection();
    load_entry(3, 22'h1800, 8'h05, 1, 0, 2'd0, 19'h01C00, 2'b01, 0);
    access("R9 user read violation", 2'd0, 32'h0060_03FF, 1, 1, 0, 12'h0A0, 0);
    access("R9 user fetch violation", 2'd2, 32'h0060_03FF, 1, 1, 0, 12'h0A0, 0);
    access("R9 user write violation", 2'd1, 32'h0060_03FF, 1, 1, 0, 12'h0C0, 0);
    access("R10 initial write", 2'd1, 32'h0060_03FF, 0, 1, 0, 12'h080, 0);
    chk("R11 tea", fault_addr, 32'h0060_03FF);
    chk("R11 pteh vpn replaced asid kept", pteh_q, 32'h0060_0005);
    access("R10 read skips dirty", 2'd0, 32'h0060_03FF, 0, 1, 0, 12'h000, 32'h0070_03FF);
    chk("R11 success keeps tea", fault_addr, 32'h0060_03FF);
    chk("R11 success keeps pteh", pteh_q, 32'h0060_0005);
    access("R7 1K page edge miss", 2'd0, 32'h0060_0400, 0, 1, 0, 12'h040, 0);
    chk("R11 pteh after miss", pteh_q, 32'h0060_0405);
  endtask

  task automatic t_multi();
    load_entry(0, 22'h1800, 8'h05, 1, 0, 2'd1, 19'h00100, 2'b11, 1);
    access("R8 multiple hit", 2'd0, 32'h0060_0100, 1, 1, 0, 12'h140, 0);
    chk("R11 multi tea", fault_addr, 32'h0060_0100);
    chk("R11 multi keeps pteh", pteh_q, 32'h0060_0405);
    load_entry(0, 22'h1800, 8'h05, 0, 0, 2'd1, 19'h00100, 2'b11, 1);
    access("R6 invalid entry ignored", 2'd0, 32'h0060_0100, 0, 1, 0, 12'h000, 32'h0070_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_areas();
    t_xlat_off();
    t_pteh_write();
    t_basic_hit();
    t_asid();
    t_big_page();
    t_protection();
    t_multi();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule